// File: doc/BRIEF.md
# Registered Address Buffer with Parity Check

This block registers the address and command lines of a memory module on the rising clock edge and drives them back out as registered values. Two static configuration inputs choose the layout. In the wide layout, 25 inputs map one-to-one onto 25 outputs. In the narrow layout, 14 inputs are registered and each registered bit drives two output copies. The upper inputs are then ignored.

Alongside the data path, the block checks even parity over a subset of the data inputs, and that subset depends on the layout. The parity bit for a word reaches the block one clock after the word itself. The block produces a partial-parity output and a sticky, active-low error flag.

Two instances can be chained so that one parity bit covers both of their input sets. In the chain, the first instance runs in the narrow layout, and its partial-parity output drives the parity input of the second instance. The second instance runs in the cascade-upper layout, and its error flag carries the combined result.

Top module: `addr_parity_buffer`

## Requirements
- R1: While rst_ni is low and right after reset, q_o and qdup_o are all zero, ppo_o is 0 and qerr_no is 1.
- R2: With cfg_c1_i=0 (wide), q_o after a rising edge equals all 25 bits of d_i sampled at that edge (q_o[k] follows d_i[k]), and qdup_o is 0.
- R3: With cfg_c1_i=1 (narrow), after an edge q_o[13:0] and qdup_o[13:0] both equal d_i[13:0] from that edge. q_o[24:14] stays 0 whatever d_i[24:14] carries.
- R4: With cfg_c0_i=0 and cfg_c1_i=0, ppo_o equals par_i XOR the checked bits d_i[1], d_i[2], d_i[4], d_i[5] and d_i[23:7] through d_i[24]. That is all of d_i except bits 0, 3 and 6.
- R5: With cfg_c0_i=0 and cfg_c1_i=1, the checked bits are d_i[1], d_i[2], d_i[4], d_i[5] and d_i[13:7].
- R6: With cfg_c0_i=1 and cfg_c1_i=1 (cascade upper), the checked bits are d_i[5:0] and d_i[12:7].
- R7: Latency is counted from the capture edge n of a word.
  - When cfg_c0_i=0, par_i for that word is sampled at edge n+1, and ppo_o for the word shows after edge n+1.
  - When cfg_c0_i=1, par_i is sampled at edge n+2, and ppo_o shows after edge n+2.
  - In both cases, qerr_no goes low after edge n+2 if the word's ppo value is 1 (odd parity).
- R8: Once low, qerr_no stays low until rst_ni is asserted.
- R9: In a chain, the first instance is narrow and the second is cascade upper, with the first instance's ppo_o driving the second instance's par_i. The second instance's qerr_no goes low exactly when the parity is odd over both instances' checked bits plus the first instance's par_i.
- R10: Unchecked inputs (bits 0, 3 and 6 in the wide layout) have no effect on ppo_o or qerr_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_c0_i | input | 1 | Static config: 1 selects cascade-upper parity timing and set |
| cfg_c1_i | input | 1 | Static config: 0 wide layout, 1 narrow layout |
| d_i | input | 25 | Data inputs |
| par_i | input | 1 | Parity input, one or two cycles behind its word |
| q_o | output | 25 | Registered data outputs |
| qdup_o | output | 14 | Second copy of q_o[13:0] in narrow layout, else 0 |
| ppo_o | output | 1 | Partial parity of the checked bits plus par_i |
| qerr_no | output | 1 | Sticky active-low parity error flag |

## Verification
Random words run with correct parity in each of the three configurations, and every cycle ppo_o is compared to a bench model that applies the parity delay. This separates the three checked-bit sets and the one- and two-edge parity sampling. Directed words toggle only the unchecked bits or only the ignored upper inputs, which shows that these inputs reach neither the parity path nor the narrow outputs. A single bad parity bit, followed by good words, exercises the error latency and stickiness. The same is then done on a chained pair, which shows that the split parity sum closes across two instances.

// File: rtl/apb_pkg.sv
package apb_pkg;
  localparam int unsigned WIDE_W   = 25;
  localparam int unsigned NARROW_W = 14;
  // bit positions left out of the narrow/wide parity sets
  localparam int unsigned GAP_A = 3;
  localparam int unsigned GAP_B = 6;

  typedef enum logic [1:0] {
    MODE_WIDE    = 2'd0,
    MODE_NARROW  = 2'd1,
    MODE_CASC_HI = 2'd2
  } mode_e;
endpackage

// File: rtl/apb_data_reg.sv
module apb_data_reg #(
  parameter int unsigned DATA_W   = apb_pkg::WIDE_W,
  parameter int unsigned NARROW_W = apb_pkg::NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                narrow_i,
  input  logic [DATA_W-1:0]   d_i,
  output logic [DATA_W-1:0]   q_o,
  output logic [NARROW_W-1:0] qdup_o
);
  localparam int unsigned UPPER_W = DATA_W - NARROW_W;

  logic [NARROW_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= '0;
    else         low_q <= d_i[NARROW_W-1:0];
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      logic [UPPER_W-1:0] up_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       up_q <= '0;
        else if (narrow_i) up_q <= '0;
        else               up_q <= d_i[DATA_W-1:NARROW_W];
      end
      assign q_o = {up_q, low_q};
    end else begin : g_no_upper
      assign q_o = low_q;
    end
  endgenerate

  // both copies come from the same register
  assign qdup_o = narrow_i ? low_q : '0;
endmodule

// File: rtl/apb_parity_fold.sv
module apb_parity_fold #(
  parameter int unsigned DATA_W   = apb_pkg::WIDE_W,
  parameter int unsigned NARROW_W = apb_pkg::NARROW_W
) (
  input  apb_pkg::mode_e    mode_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              part_o
);
  import apb_pkg::*;

  logic [DATA_W-1:0] mask_wide, mask_narrow, mask_casc, mask_sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    localparam bit IN_GAP = (i == GAP_A) || (i == GAP_B);
    assign mask_wide[i]   = (i != 0) && !IN_GAP;
    assign mask_narrow[i] = (i != 0) && !IN_GAP && (i < NARROW_W);
    assign mask_casc[i]   = (i != GAP_B) && (i < NARROW_W - 1);
  end

  always_comb begin
    unique case (mode_i)
      MODE_NARROW:  mask_sel = mask_narrow;
      MODE_CASC_HI: mask_sel = mask_casc;
      default:      mask_sel = mask_wide;
    endcase
  end

  assign part_o = ^(d_i & mask_sel);
endmodule

// File: rtl/apb_parity_track.sv
module apb_parity_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic casc_hi_i,
  input  logic part_i,
  input  logic par_i,
  output logic ppo_o,
  output logic qerr_no
);
  logic part_q, part_dly_q, ppo_q, err_q;
  logic late_sum;

  assign late_sum = part_dly_q ^ par_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q     <= 1'b0;
      part_dly_q <= 1'b0;
      ppo_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      part_q     <= part_i;
      part_dly_q <= part_q;
      if (casc_hi_i) begin
        // parity comes from an upstream ppo, one stage later
        ppo_q <= late_sum;
        err_q <= err_q | late_sum;
      end else begin
        ppo_q <= part_q ^ par_i;
        err_q <= err_q | ppo_q;
      end
    end
  end

  assign ppo_o   = ppo_q;
  assign qerr_no = ~err_q;
endmodule

// File: rtl/addr_parity_buffer.sv
module addr_parity_buffer #(
  parameter int unsigned DATA_W   = apb_pkg::WIDE_W,
  parameter int unsigned NARROW_W = apb_pkg::NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_c0_i,
  input  logic                cfg_c1_i,
  input  logic [DATA_W-1:0]   d_i,
  input  logic                par_i,
  output logic [DATA_W-1:0]   q_o,
  output logic [NARROW_W-1:0] qdup_o,
  output logic                ppo_o,
  output logic                qerr_no
);
  import apb_pkg::*;

  mode_e mode;
  logic  casc_hi, part;

  assign casc_hi = cfg_c0_i & cfg_c1_i;
  assign mode    = !cfg_c1_i ? MODE_WIDE : (cfg_c0_i ? MODE_CASC_HI : MODE_NARROW);

  apb_data_reg #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_data_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .narrow_i (cfg_c1_i),
    .d_i      (d_i),
    .q_o      (q_o),
    .qdup_o   (qdup_o)
  );

  apb_parity_fold #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_fold (
    .mode_i (mode),
    .d_i    (d_i),
    .part_o (part)
  );

  apb_parity_track i_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .casc_hi_i (casc_hi),
    .part_i    (part),
    .par_i     (par_i),
    .ppo_o     (ppo_o),
    .qerr_no   (qerr_no)
  );
endmodule

// File: rtl/addr_parity_buffer_chk.sv
module addr_parity_buffer_chk #(
  parameter int unsigned DATA_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_c0_i,
  input logic                cfg_c1_i,
  input logic [DATA_W-1:0]   d_i,
  input logic                par_i,
  input logic [DATA_W-1:0]   q_o,
  input logic [NARROW_W-1:0] qdup_o,
  input logic                ppo_o,
  input logic                qerr_no
);
  logic unused_par;
  assign unused_par = par_i;

  // R8
  a_r8_sticky_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qerr_no |=> !qerr_no);

  // R2
  a_r2_wide_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !cfg_c1_i && !$past(cfg_c1_i)) |-> (q_o == $past(d_i)));

  a_r2_wide_nodup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_c1_i |-> (qdup_o == '0));

  // R3
  a_r3_dup_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_c1_i |-> (qdup_o == q_o[NARROW_W-1:0]));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cfg_c1_i && $past(cfg_c1_i)) |-> (q_o[DATA_W-1:NARROW_W] == '0));

  // R7
  a_r7_err_follows_ppo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_c0_i && ppo_o) |=> !qerr_no);
endmodule

bind addr_parity_buffer addr_parity_buffer_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_chk (.*);

// File: tb/test_addr_parity_buffer.sv
`timescale 1ns/1ps
module test_addr_parity_buffer;
  localparam int W = 25;
  localparam int N = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0;
  logic [W-1:0] d_m = '0, d_lo = '0, d_hi = '0;
  logic par_m = 1'b0, par_lo = 1'b0;
  logic [W-1:0] q_m, q_lo, q_hi;
  logic [N-1:0] dup_m, dup_lo, dup_hi;
  logic ppo_m, ppo_lo, ppo_hi, err_m, err_lo, err_hi;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  addr_parity_buffer i_addr_parity_buffer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_c0_i(c0), .cfg_c1_i(c1), .d_i(d_m), .par_i(par_m),
    .q_o(q_m), .qdup_o(dup_m), .ppo_o(ppo_m), .qerr_no(err_m));

  addr_parity_buffer i_casc_lo (
    .clk_i(clk), .rst_ni(rst_n), .cfg_c0_i(1'b0), .cfg_c1_i(1'b1), .d_i(d_lo), .par_i(par_lo),
    .q_o(q_lo), .qdup_o(dup_lo), .ppo_o(ppo_lo), .qerr_no(err_lo));

  addr_parity_buffer i_casc_hi (
    .clk_i(clk), .rst_ni(rst_n), .cfg_c0_i(1'b1), .cfg_c1_i(1'b1), .d_i(d_hi), .par_i(ppo_lo),
    .q_o(q_hi), .qdup_o(dup_hi), .ppo_o(ppo_hi), .qerr_no(err_hi));

  // model state
  logic [W-1:0] m_w1, m_w2, l_w1, h_w1, h_w2;
  logic m_ppo, m_err, l_ppo, h_err;
  string ppo_tag;

  function automatic logic [W-1:0] mask_of(input logic a0, input logic a1);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      if (!a1)     m[i] = (i != 0) && (i != 3) && (i != 6);
      else if (!a0) m[i] = (i >= 1) && (i <= 13) && (i != 3) && (i != 6);
      else         m[i] = (i <= 12) && (i != 6);
    end
    return m;
  endfunction

  function automatic logic fold(input logic a0, input logic a1, input logic [W-1:0] w);
    return ^(w & mask_of(a0, a1));
  endfunction

  function automatic logic [W-1:0] q_model(input logic a1, input logic [W-1:0] w);
    return a1 ? {{(W-N){1'b0}}, w[N-1:0]} : w;
  endfunction

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic a0, input logic a1);
    @(negedge clk);
    rst_n = 1'b0; c0 = a0; c1 = a1;
    d_m = '0; d_lo = '0; d_hi = '0; par_m = 0; par_lo = 0;
    m_w1 = '0; m_w2 = '0; l_w1 = '0; h_w1 = '0; h_w2 = '0;
    m_ppo = 0; m_err = 0; l_ppo = 0; h_err = 0;
    @(negedge clk);
    chk("R1", "q", q_m, '0);
    chk("R1", "qdup", {{(W-N){1'b0}}, dup_m}, '0);
    chk("R1", "ppo", {{(W-1){1'b0}}, ppo_m}, '0);
    chk("R1", "qerr", {{(W-1){1'b0}}, err_m}, 1);
    chk("R1", "casc qerr", {{(W-1){1'b0}}, err_hi}, 1);
    rst_n = 1'b1;
  endtask

  // good parity bit for the main instance at this step
  function automatic logic good_par_m();
    return c0 ? fold(c0, c1, m_w2) : fold(c0, c1, m_w1);
  endfunction

  function automatic logic good_par_lo();
    return fold(1'b0, 1'b1, l_w1) ^ fold(1'b1, 1'b1, h_w1);
  endfunction

  task automatic step(input logic [W-1:0] dm, input logic pm,
                      input logic [W-1:0] dl, input logic [W-1:0] dh, input logic pl);
    logic np, ne, nl, nh, prev_err;
    d_m = dm; par_m = pm; d_lo = dl; d_hi = dh; par_lo = pl;
    @(posedge clk);
    prev_err = m_err;
    if (!c0) begin np = fold(c0, c1, m_w1) ^ pm; ne = m_err | m_ppo; end
    else     begin np = fold(c0, c1, m_w2) ^ pm; ne = m_err | np;    end
    m_w2 = m_w1; m_w1 = dm; m_ppo = np; m_err = ne;
    nl = fold(1'b0, 1'b1, l_w1) ^ pl;
    nh = fold(1'b1, 1'b1, h_w2) ^ l_ppo;
    h_err = h_err | nh;
    l_ppo = nl; l_w1 = dl; h_w2 = h_w1; h_w1 = dh;
    @(negedge clk);
    chk(c1 ? "R3" : "R2", "q", q_m, q_model(c1, dm));
    chk(c1 ? "R3" : "R2", "qdup", {{(W-N){1'b0}}, dup_m}, c1 ? {{(W-N){1'b0}}, dm[N-1:0]} : '0);
    chk(ppo_tag, "ppo", {{(W-1){1'b0}}, ppo_m}, {{(W-1){1'b0}}, m_ppo});
    chk(prev_err ? "R8" : "R7", "qerr", {{(W-1){1'b0}}, err_m}, {{(W-1){1'b0}}, ~m_err});
    chk("R9", "casc ppo", {{(W-1){1'b0}}, ppo_lo}, {{(W-1){1'b0}}, l_ppo});
    chk("R9", "casc qerr", {{(W-1){1'b0}}, err_hi}, {{(W-1){1'b0}}, ~h_err});
  endtask

  task automatic run_mode(input logic a0, input logic a1, input string tag, input logic casc_bad);
    logic [W-1:0] r, rl, rh;
    do_reset(a0, a1);
    ppo_tag = tag;
    for (int k = 0; k < 40; k++) begin
      r = {$urandom, $urandom}; rl = {$urandom}; rh = {$urandom};
      step(r, good_par_m(), rl, rh, good_par_lo());
    end
    // single bad parity, then good words: error latency and stickiness
    r = {$urandom}; rl = {$urandom}; rh = {$urandom};
    step(r, ~good_par_m(), rl, rh, casc_bad ? ~good_par_lo() : good_par_lo());
    for (int k = 0; k < 8; k++) begin
      r = {$urandom}; rl = {$urandom}; rh = {$urandom};
      step(r, good_par_m(), rl, rh, good_par_lo());
    end
  endtask

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd4242));
    m_w1 = '0; m_w2 = '0; l_w1 = '0; h_w1 = '0; h_w2 = '0;
    m_ppo = 0; m_err = 0; l_ppo = 0; h_err = 0; ppo_tag = "R4";

    run_mode(1'b0, 1'b0, "R4", 1'b0);
    run_mode(1'b0, 1'b1, "R5", 1'b0);
    run_mode(1'b1, 1'b1, "R6", 1'b1);

    // R10: only unchecked bits toggle, parity bit held 0
    do_reset(1'b0, 1'b0);
    ppo_tag = "R10";
    for (int k = 0; k < 12; k++) begin
      r = '0; r[0] = $urandom; r[3] = $urandom; r[6] = $urandom;
      step(r, 1'b0, '0, '0, 1'b0);
    end
    chk("R10", "qerr held", {{(W-1){1'b0}}, err_m}, 1);

    // R3: ignored upper inputs in narrow layout
    do_reset(1'b0, 1'b1);
    ppo_tag = "R5";
    for (int k = 0; k < 8; k++) begin
      r = '0; r[W-1:N] = $urandom;
      step(r, good_par_m(), '0, '0, 1'b0);
    end
    chk("R3", "upper q", q_m, '0);

    // R7: bad parity on a single walking-one word, error after two edges
    do_reset(1'b0, 1'b0);
    ppo_tag = "R7";
    step(25'h0000100, 1'b0, '0, '0, 1'b0);
    step('0, 1'b0, '0, '0, 1'b0);
    chk("R7", "qerr one edge after parity", {{(W-1){1'b0}}, err_m}, 1);
    step('0, 1'b0, '0, '0, 1'b0);
    chk("R7", "qerr after second edge", {{(W-1){1'b0}}, err_m}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule